// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A single test clock, a mode-select line and a serial data input drive the standard sixteen-state test-port controller. Through it, an external tester loads a 3-bit instruction and then shifts one of three data registers through the chip. The data registers are a one-bit bypass stage, a 32-bit identification word and a boundary register with one cell per monitored pin. The boundary register captures the pin levels in parallel.

The instruction also decides whether the functional data pins must be released to high impedance while the boundary cells sample them. The serial output changes on the falling edge of the test clock. It is enabled only while a register is being shifted. There is no separate test reset pin. A synchronous power-up reset, or five clocks with the mode-select line held high, returns the controller to its reset state, and that state selects the identification instruction.

Top module: `tap_scan_port`

## Requirements
- R1: After reset the controller is in Test-Logic-Reset, the serial output enable is 0 and the high-impedance control is 0. Every rising edge spent in Test-Logic-Reset sets the instruction to 001, which selects the identification register.
- R2: From any state, five rising edges with mode-select high bring the controller to Test-Logic-Reset. One further rising edge restores instruction 001 and releases the high-impedance control.
- R3: Instructions 000, 010 and 100 select the boundary register, which is BSR_LEN bits long. Instruction 001 selects the 32-bit identification register. Instructions 011, 101, 110 and 111 select the 1-bit bypass register.
- R4: The high-impedance control is 1 exactly while the active instruction is 000 or 010. It is 0 for every other instruction, including 100.
- R5: The identification word captured at Capture-DR holds the revision in bits 31:28, the configuration in 27:18, the vendor field in 17:12 and the manufacturer code in 11:1. Bit 0 is always 1.
- R6: The bypass register is 0 once a bypass-selecting instruction takes effect, and it captures 0 at Capture-DR. Data shifted through it therefore appears one bit late, behind a leading 0.
- R7: Capture-IR loads 001 into the instruction shift stage. Shift-IR sends it out least significant bit first, so the tester reads 1, 0, 0.
- R8: Capture-DR under a boundary instruction samples the parallel pin inputs. Bit 0 leaves first, and serial input enters at bit BSR_LEN-1.
- R9: The serial output and its enable change only on falling edges of the test clock. The enable is 1 only after a falling edge in Shift-IR or Shift-DR.
- R10: A newly shifted instruction changes nothing until the rising edge that leaves Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| bnd_in | input | BSR_LEN | Parallel pin levels captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for tdo (1 = driven) |
| pins_hiz | output | 1 | Forces the functional data pins to high impedance |

## Verification
A wrong controller state shows within one falling edge as a wrong tdo_oe value. It also shows within one scan as a register path of the wrong length: a bypass path one bit long, an identification path 32 bits long, or a boundary path BSR_LEN bits long. A wrong instruction decode shows on pins_hiz at the rising edge that leaves Update-IR. The bench sweeps all eight opcodes and measures each path length by shifting a known pattern through it. It checks both timing rules: pins_hiz must hold until Update-IR is left, and the output enable must wait for the falling edge. It also forces a return to reset from both the data branch and the instruction branch of the state diagram.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int unsigned IR_BITS = 3;
  typedef logic [IR_BITS-1:0] opcode_t;

  localparam opcode_t OP_EXTEST  = 3'b000;
  localparam opcode_t OP_IDCODE  = 3'b001;
  localparam opcode_t OP_SAMPLEZ = 3'b010;
  localparam opcode_t OP_SAMPLE  = 3'b100;
  localparam opcode_t IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {PATH_BSR, PATH_ID, PATH_BYP} dr_path_t;

  function automatic dr_path_t path_of(opcode_t op);
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: path_of = PATH_BSR;
      OP_IDCODE:                        path_of = PATH_ID;
      default:                          path_of = PATH_BYP;
    endcase
  endfunction

  function automatic logic hiz_of(opcode_t op);
    hiz_of = (op == OP_EXTEST) || (op == OP_SAMPLEZ);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    case (state)
      ST_TLR:      nxt = tms ? ST_TLR      : ST_RTI;
      ST_RTI:      nxt = tms ? ST_SEL_DR   : ST_RTI;
      ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
      ST_SEL_IR:   nxt = tms ? ST_TLR      : ST_CAP_IR;
      ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
      default:     nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= nxt;
  end

  // consecutive mode-select-high edges, saturating at five
  logic [2:0] ones;
  always_ff @(posedge tck) begin
    if (rst || !tms)      ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (rst)
    (ones == 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_t state,
  input  logic       tdi,
  output logic       ir_lsb,
  output dr_path_t   path,
  output logic       hiz,
  output logic       upd_to_bypass
);

  opcode_t ir_sh;
  opcode_t ir_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh <= '0;
    end else if (state == ST_CAP_IR) begin
      ir_sh <= IR_CAPTURE;
    end else if (state == ST_SHIFT_IR) begin
      ir_sh <= {tdi, ir_sh[IR_BITS-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst || state == ST_TLR) begin
      ir_q <= OP_IDCODE;
      hiz  <= 1'b0;
    end else if (state == ST_UPD_IR) begin
      ir_q <= ir_sh;
      hiz  <= hiz_of(ir_sh);
    end
  end

  assign ir_lsb        = ir_sh[0];
  assign path          = path_of(ir_q);
  assign upd_to_bypass = (state == ST_UPD_IR) && (path_of(ir_sh) == PATH_BYP);

  assert_capture_pattern_R7: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_sh == IR_CAPTURE));

  assert_hiz_only_boundary_R4: assert property (@(posedge tck) disable iff (rst)
    hiz |-> (path == PATH_BSR));

  assert_reset_selects_id_R1: assert property (@(posedge tck) disable iff (rst)
    (state == ST_TLR) |=> (ir_q == OP_IDCODE && !hiz));

  assert_instr_holds_R10: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_IR && state != ST_TLR) |=> ($stable(ir_q) && $stable(hiz)));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int unsigned BSR_LEN = 121,
  parameter logic [3:0]  ID_REV  = 4'h2,
  parameter logic [9:0]  ID_CFG  = 10'h125,
  parameter logic [5:0]  ID_VEND = 6'h0B,
  parameter logic [10:0] ID_MFR  = 11'h2A5
) (
  input  logic               tck,
  input  logic               rst,
  input  tap_state_t         state,
  input  logic               tdi,
  input  dr_path_t           path,
  input  logic               upd_to_bypass,
  input  logic [BSR_LEN-1:0] pins,
  output logic               dr_lsb
);

  localparam int unsigned ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_CFG, ID_VEND, ID_MFR, 1'b1};

  logic cap, sft;
  assign cap = (state == ST_CAP_DR);
  assign sft = (state == ST_SHIFT_DR);

  // bypass stage
  logic byp;
  always_ff @(posedge tck) begin
    if (rst || upd_to_bypass)               byp <= 1'b0;
    else if (path == PATH_BYP && cap)       byp <= 1'b0;
    else if (path == PATH_BYP && sft)       byp <= tdi;
  end

  // identification shift register
  logic [ID_W-1:0] id_sh;
  always_ff @(posedge tck) begin
    if (rst)                                id_sh <= '0;
    else if (path == PATH_ID && cap)        id_sh <= ID_WORD;
    else if (path == PATH_ID && sft)        id_sh <= {tdi, id_sh[ID_W-1:1]};
  end

  // boundary cells: each captures its pin or takes its upper neighbour
  logic [BSR_LEN-1:0] bsr;
  logic               bsr_cap, bsr_sft;
  assign bsr_cap = (path == PATH_BSR) && cap;
  assign bsr_sft = (path == PATH_BSR) && sft;

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic shin;
    if (i == BSR_LEN - 1) begin : g_top
      assign shin = tdi;
    end else begin : g_mid
      assign shin = bsr[i+1];
    end
    always_ff @(posedge tck) begin
      if (rst)          bsr[i] <= 1'b0;
      else if (bsr_cap) bsr[i] <= pins[i];
      else if (bsr_sft) bsr[i] <= shin;
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_sh[0];
      PATH_BSR: dr_lsb = bsr[0];
      default:  dr_lsb = byp;
    endcase
  end

  assert_bypass_cleared_R6: assert property (@(posedge tck) disable iff (rst)
    upd_to_bypass |=> (byp == 1'b0));

  assert_id_layout_R5: assert property (@(posedge tck) disable iff (rst)
    (cap && path == PATH_ID) |=> (id_sh[0] == 1'b1 && id_sh[31:28] == ID_REV
                                  && id_sh[11:1] == ID_MFR));

  assert_bsr_capture_R8: assert property (@(posedge tck) disable iff (rst)
    bsr_cap |=> (bsr == $past(pins)));

endmodule

// File: rtl/tap_scan_port.sv
module tap_scan_port
  import tap_pkg::*;
#(
  parameter int unsigned BSR_LEN = 121,
  parameter logic [3:0]  ID_REV  = 4'h2,
  parameter logic [9:0]  ID_CFG  = 10'h125,
  parameter logic [5:0]  ID_VEND = 6'h0B,
  parameter logic [10:0] ID_MFR  = 11'h2A5
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bnd_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               pins_hiz
);

  tap_state_t state;
  dr_path_t   path;
  logic       ir_lsb, dr_lsb, upd_to_bypass;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck           (tck),
    .rst           (rst),
    .state         (state),
    .tdi           (tdi),
    .ir_lsb        (ir_lsb),
    .path          (path),
    .hiz           (pins_hiz),
    .upd_to_bypass (upd_to_bypass)
  );

  tap_dr #(
    .BSR_LEN (BSR_LEN),
    .ID_REV  (ID_REV),
    .ID_CFG  (ID_CFG),
    .ID_VEND (ID_VEND),
    .ID_MFR  (ID_MFR)
  ) u_dr (
    .tck           (tck),
    .rst           (rst),
    .state         (state),
    .tdi           (tdi),
    .path          (path),
    .upd_to_bypass (upd_to_bypass),
    .pins          (bnd_in),
    .dr_lsb        (dr_lsb)
  );

  // serial output retimed to the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SHIFT_IR) || (state == ST_SHIFT_DR);
      if (state == ST_SHIFT_IR)      tdo <= ir_lsb;
      else if (state == ST_SHIFT_DR) tdo <= dr_lsb;
    end
  end

  assert_oe_in_shift_R9: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == ST_SHIFT_IR || state == ST_SHIFT_DR));

endmodule

// File: tb/tap_scan_port_test.sv
module tap_scan_port_test;

  localparam int unsigned BSR_LEN = 12;
  localparam logic [3:0]  REV  = 4'h9;
  localparam logic [9:0]  CFG  = 10'h2C3;
  localparam logic [5:0]  VEND = 6'h15;
  localparam logic [10:0] MFR  = 11'h4E1;
  localparam logic [31:0] EXP_ID = {REV, CFG, VEND, MFR, 1'b1};
  localparam int SL = 40;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b1;
  logic [BSR_LEN-1:0] pins = '0;
  logic tdo, tdo_oe, hiz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 tck = ~tck;

  tap_scan_port #(
    .BSR_LEN (BSR_LEN), .ID_REV (REV), .ID_CFG (CFG), .ID_VEND (VEND), .ID_MFR (MFR)
  ) uut (
    .tck (tck), .rst (rst), .tms (tms), .tdi (tdi), .bnd_in (pins),
    .tdo (tdo), .tdo_oe (tdo_oe), .pins_hiz (hiz)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle: load an opcode, return to Run-Test/Idle
  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap, output logic hiz_mid);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 0);
    hiz_mid = hiz;
    step(0, 0);
  endtask

  task automatic scan_dr(input logic [SL-1:0] din, output logic [SL-1:0] dout);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < SL; i++) begin
      dout[i] = tdo;
      step(i == SL - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [SL-1:0] expect_scan(input logic [2:0] op,
      input logic [BSR_LEN-1:0] p, input logic [SL-1:0] din);
    int len;
    logic [63:0] cont;
    logic [SL-1:0] r;
    case (op)
      3'd0, 3'd2, 3'd4: begin len = BSR_LEN; cont = 64'(p); end
      3'd1:             begin len = 32;      cont = 64'(EXP_ID); end
      default:          begin len = 1;       cont = 64'd0; end
    endcase
    for (int i = 0; i < SL; i++)
      r[i] = (i < len) ? cont[i] : din[i - len];
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SL-1:0] din, dout;
    logic [2:0]    cap;
    logic          hmid, prev_hiz, exp_hiz;

    repeat (3) @(negedge tck);
    #1 rst = 1'b0;

    // R1: reset state
    chk(tdo_oe == 1'b0, "R1 oe after reset", 64'(tdo_oe), 0);
    chk(hiz == 1'b0, "R1 hiz after reset", 64'(hiz), 0);
    step(0, 0);
    din = 40'hC3_5A96_1E7B;
    scan_dr(din, dout);
    chk(dout == expect_scan(3'd1, pins, din), "R1 id selected after reset",
        64'(dout), 64'(expect_scan(3'd1, pins, din)));
    chk(dout[0] == 1'b1, "R5 id bit0", 64'(dout[0]), 1);
    chk(dout[31:28] == REV && dout[27:18] == CFG && dout[17:12] == VEND && dout[11:1] == MFR,
        "R5 id fields", 64'(dout[31:0]), 64'(EXP_ID));

    // sweep of every opcode
    prev_hiz = 1'b0;
    for (int op = 0; op < 8; op++) begin
      pins = BSR_LEN'(12'hA5C ^ (op * 12'h111));
      load_ir(3'(op), cap, hmid);
      chk(cap == 3'b001, "R7 capture-ir pattern", 64'(cap), 1);
      chk(hmid == prev_hiz, "R10 hiz held until update", 64'(hmid), 64'(prev_hiz));
      exp_hiz = (op == 0) || (op == 2);
      chk(hiz == exp_hiz, "R4 hiz decode", 64'(hiz), 64'(exp_hiz));
      din = 40'h96_0F3C_A5E1 ^ (40'(op) * 40'h11_1111_1111);
      scan_dr(din, dout);
      chk(dout == expect_scan(3'(op), pins, din), "R3 R6 R8 path contents and length",
          64'(dout), 64'(expect_scan(3'(op), pins, din)));
      chk(hiz == exp_hiz, "R4 hiz stable over dr scan", 64'(hiz), 64'(exp_hiz));
      chk(tdo_oe == 1'b0, "R9 oe low in idle", 64'(tdo_oe), 0);
      prev_hiz = exp_hiz;
    end

    // R2: forced return from the data branch with EXTEST active
    load_ir(3'b000, cap, hmid);
    chk(hiz == 1'b1, "R4 extest hiz", 64'(hiz), 1);
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 1);
    chk(hiz == 1'b1, "R2 hiz held on arrival in reset state", 64'(hiz), 1);
    step(1, 1);
    chk(hiz == 1'b0, "R2 hiz released after reset state", 64'(hiz), 0);
    step(0, 0);
    din = 40'h5_5AA5_33CC;
    scan_dr(din, dout);
    chk(dout == expect_scan(3'd1, pins, din), "R2 id restored",
        64'(dout), 64'(expect_scan(3'd1, pins, din)));

    // R2: forced return from Pause-IR with SAMPLE-Z active
    load_ir(3'b010, cap, hmid);
    step(1, 0); step(1, 0); step(0, 0); step(0, 1); step(1, 0); step(0, 0);
    for (int i = 0; i < 6; i++) step(1, 0);
    chk(hiz == 1'b0, "R2 hiz released from instruction branch", 64'(hiz), 0);
    step(0, 0);

    // R9: enable changes on the falling edge, not the rising one
    step(1, 0); step(0, 0);
    tms = 1'b0;
    @(posedge tck); #1;
    chk(tdo_oe == 1'b0, "R9 oe unchanged at rising edge", 64'(tdo_oe), 0);
    @(negedge tck); #1;
    chk(tdo_oe == 1'b1, "R9 oe set at falling edge", 64'(tdo_oe), 1);
    chk(tdo == 1'b1, "R9 first id bit on tdo", 64'(tdo), 1);
    step(1, 0); step(1, 0); step(0, 0);
    chk(tdo_oe == 1'b0, "R9 oe cleared after shift", 64'(tdo_oe), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule